// File: doc/BRIEF.md
# Asymmetric Switch Debouncer

This block cleans up a single mechanical switch contact. The raw pin is first passed through a two-flop synchronizer. It is then sampled once per debounce tick, and the tick is produced by a prescaler running off the system clock. A change of the filtered level is accepted only when the sampled value has disagreed with the current filtered level on a set number of consecutive ticks. That number is small when entering the pressed state and large when leaving it. This lets a short deliberate press register quickly, while contact chatter on release is held off for much longer.

The filter is a four-state machine:

- `ST_RELEASED`: the filtered level is released and no disagreement is pending.
- `ST_PRESS_CHECK`: the filtered level is still released, but a pressed sample has been seen and the press count is running down.
- `ST_PRESSED`: the filtered level is pressed and no disagreement is pending.
- `ST_RELEASE_CHECK`: the filtered level is still pressed, but a released sample has been seen and the release count is running down.

The transitions are these:

- *start-press*: from `ST_RELEASED` to `ST_PRESS_CHECK`.
- *press-accept*: from `ST_RELEASED` or `ST_PRESS_CHECK` to `ST_PRESSED`, when the count expires.
- *press-abort*: from `ST_PRESS_CHECK` back to `ST_RELEASED`.
- *start-release*: from `ST_PRESSED` to `ST_RELEASE_CHECK`.
- *release-accept*: from `ST_PRESSED` or `ST_RELEASE_CHECK` to `ST_RELEASED`, when the count expires.
- *release-abort*: from `ST_RELEASE_CHECK` back to `ST_PRESSED`.

Every abort reloads the counter. Every accept loads the counter for leaving the newly entered state.

The tick period and both stability intervals are parameters given in milliseconds. Each count is the interval divided by the tick period, and is never less than 1. The switch polarity is also a parameter. With the defaults, the contact is active low, sampling happens every 5 ms, a press needs 2 ticks and a release needs 20 ticks.

Top module: `switch_filter`

## Requirements
- R1: While reset is asserted and after it is released, `db_level` is the released level (high for the default active-low polarity), `pressed` is 0 and `changed` is 0. The counter starts loaded with the press count.
- R2: From the released state, the filtered level becomes the pressed level on exactly the PRESS-count-th consecutive tick whose sample is pressed. With 5 ms ticks and a 10 ms press interval, that is the 2nd tick.
- R3: From the pressed state, the filtered level becomes the released level on exactly the RELEASE-count-th consecutive tick whose sample is released. The release count is independent of the press count.
- R4: Any tick whose sample agrees with the filtered level reloads the counter with the count for leaving the current state. A disagreement shorter than that count therefore never changes `db_level`.
- R5: `changed` is high for exactly one clock, in the same cycle that `db_level` first shows its new value. It is low in every other cycle.
- R6: `pressed` is 1 exactly when `db_level` equals the pressed polarity. For the default active-low switch, that means `db_level` is 0.
- R7: The raw input is looked at only on tick cycles. `db_level` can change only on the clock that follows a tick, and it is held constant between ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_raw | input | 1 | Asynchronous raw switch contact |
| db_level | output | 1 | Debounced switch level, same polarity as `sw_raw` |
| changed | output | 1 | One-clock pulse when `db_level` takes a new value |
| pressed | output | 1 | 1 while the debounced switch is in the pressed state |

## Verification
The hardest case to reach from the ports is an abort one tick before a count would expire. A single agreeing sample inside an otherwise complete run of disagreeing samples must reload the counter, so that the full interval has to be repeated. The stimulus reaches this case by phase-locking itself to the prescaler. After reset it counts clock edges, so that exactly one raw value is presented per tick. It can then place a one-tick glitch at a chosen position, both in the short press window and in the long release window. A reset applied while a press is half counted shows that the startup load of the press count governs the first press afterwards.

// File: rtl/sf_pkg.sv
package sf_pkg;

    typedef enum logic [1:0] {
        ST_RELEASED      = 2'd0,
        ST_PRESS_CHECK   = 2'd1,
        ST_PRESSED       = 2'd2,
        ST_RELEASE_CHECK = 2'd3
    } sf_state_e;

    // Number of sample ticks covering an interval, at least one.
    function automatic int ticks_for(input int interval_ms, input int tick_ms);
        int t;
        t = interval_ms / tick_ms;
        return (t < 1) ? 1 : t;
    endfunction

endpackage

// File: rtl/sf_prescaler.sv
module sf_prescaler #(
    parameter int DIVIDE = 625000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DIV_W = $clog2((DIVIDE > 1) ? DIVIDE : 2);
    localparam logic [DIV_W-1:0] LAST = DIV_W'(DIVIDE - 1);

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            tick  <= 1'b0;
        end else if (div_q == LAST) begin
            div_q <= '0;
            tick  <= 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/sf_sync.sv
module sf_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/sf_fsm.sv
module sf_fsm
    import sf_pkg::*;
#(
    parameter int PRESS_TICKS   = 2,
    parameter int RELEASE_TICKS = 20,
    parameter int CNT_W         = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             active,
    output logic             is_pressed,
    output logic             accept_pulse,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] PRESS_LD   = CNT_W'(PRESS_TICKS);
    localparam logic [CNT_W-1:0] RELEASE_LD = CNT_W'(RELEASE_TICKS);
    localparam logic [CNT_W-1:0] LAST_ONE   = CNT_W'(1);

    sf_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             accept_d;

    // Next-state and counter logic
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        accept_d = 1'b0;
        if (tick) begin
            unique case (state_q)
                ST_RELEASED, ST_PRESS_CHECK: begin
                    if (active) begin
                        if (cnt_q == LAST_ONE) begin
                            state_d  = ST_PRESSED;       // press-accept
                            cnt_d    = RELEASE_LD;
                            accept_d = 1'b1;
                        end else begin
                            state_d  = ST_PRESS_CHECK;   // start-press / keep counting
                            cnt_d    = cnt_q - 1'b1;
                        end
                    end else begin
                        state_d = ST_RELEASED;           // press-abort / idle reload
                        cnt_d   = PRESS_LD;
                    end
                end
                ST_PRESSED, ST_RELEASE_CHECK: begin
                    if (!active) begin
                        if (cnt_q == LAST_ONE) begin
                            state_d  = ST_RELEASED;      // release-accept
                            cnt_d    = PRESS_LD;
                            accept_d = 1'b1;
                        end else begin
                            state_d  = ST_RELEASE_CHECK; // start-release / keep counting
                            cnt_d    = cnt_q - 1'b1;
                        end
                    end else begin
                        state_d = ST_PRESSED;            // release-abort / idle reload
                        cnt_d   = RELEASE_LD;
                    end
                end
                default: begin
                    state_d = ST_RELEASED;
                    cnt_d   = PRESS_LD;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RELEASED;
            cnt_q   <= PRESS_LD;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Registered outputs, updated on the same edge as the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_pressed   <= 1'b0;
            accept_pulse <= 1'b0;
        end else begin
            is_pressed   <= (state_d == ST_PRESSED) || (state_d == ST_RELEASE_CHECK);
            accept_pulse <= accept_d;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/switch_filter.sv
module switch_filter
    import sf_pkg::*;
#(
    parameter int   TICK_CYCLES = 625000,
    parameter int   TICK_MS     = 5,
    parameter int   PRESS_MS    = 10,
    parameter int   RELEASE_MS  = 100,
    parameter logic PRESS_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_raw,
    output logic db_level,
    output logic changed,
    output logic pressed
);
    localparam int PRESS_TICKS   = ticks_for(PRESS_MS, TICK_MS);
    localparam int RELEASE_TICKS = ticks_for(RELEASE_MS, TICK_MS);
    localparam int MAX_TICKS     = (PRESS_TICKS > RELEASE_TICKS) ? PRESS_TICKS : RELEASE_TICKS;
    localparam int CNT_W         = $clog2(MAX_TICKS + 1);

    logic             tick_w;
    logic             sample_w;
    logic             is_pressed_w;
    logic [CNT_W-1:0] cnt_w;

    sf_prescaler #(.DIVIDE(TICK_CYCLES)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_w)
    );

    sf_sync #(.RST_VAL(~PRESS_LEVEL)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (sw_raw),
        .q_sync  (sample_w)
    );

    sf_fsm #(
        .PRESS_TICKS   (PRESS_TICKS),
        .RELEASE_TICKS (RELEASE_TICKS),
        .CNT_W         (CNT_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick_w),
        .active       (sample_w == PRESS_LEVEL),
        .is_pressed   (is_pressed_w),
        .accept_pulse (changed),
        .cnt          (cnt_w)
    );

    assign pressed  = is_pressed_w;
    assign db_level = is_pressed_w ? PRESS_LEVEL : ~PRESS_LEVEL;
endmodule

// File: rtl/sf_checker.sv
module sf_checker #(
    parameter int CNT_W     = 6,
    parameter int MAX_TICKS = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             db_level,
    input logic             changed,
    input logic [CNT_W-1:0] cnt
);
    // R5: the change indication lasts one clock only
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        changed |=> !changed);

    // R5: level moves exactly when the pulse is high
    assert_level_moves_with_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(db_level) |-> changed);

    assert_pulse_means_move_R5: assert property (@(posedge clk) disable iff (!rst_n)
        changed |-> !$stable(db_level));

    // R7: the level only moves on the clock after a tick
    assert_move_after_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(db_level) |-> $past(tick));

    // R4: the counter stays inside its loadable range
    assert_count_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) && (cnt <= CNT_W'(MAX_TICKS)));

    // R4: without a tick the counter holds
    assert_count_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable(cnt));
endmodule

bind switch_filter sf_checker #(
    .CNT_W     (CNT_W),
    .MAX_TICKS (MAX_TICKS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_w),
    .db_level (db_level),
    .changed  (changed),
    .cnt      (cnt_w)
);

// File: tb/sim_switch_filter.sv
`timescale 1ns/1ps
module sim_switch_filter;
    localparam int T = 4;      // clocks per tick in this bench
    localparam int NV = 27;

    // {sw_raw, expected db_level, expected changed}; press = 2 ticks, release = 6 ticks
    localparam logic [2:0] VEC [NV] = '{
        3'b110, 3'b010, 3'b110, 3'b010, 3'b001, 3'b000,
        3'b100, 3'b100, 3'b100, 3'b100, 3'b000,
        3'b100, 3'b100, 3'b100, 3'b100, 3'b100, 3'b111,
        3'b110, 3'b010, 3'b001,
        3'b100, 3'b100, 3'b100, 3'b100, 3'b100, 3'b111, 3'b110
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_raw = 1'b1;
    logic db_level, changed, pressed;

    int edge_cnt = 0;
    int tick_no = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) begin
        if (!rst_n) edge_cnt <= 0;
        else        edge_cnt <= edge_cnt + 1;
    end

    switch_filter #(
        .TICK_CYCLES (T),
        .TICK_MS     (5),
        .PRESS_MS    (10),
        .RELEASE_MS  (30),
        .PRESS_LEVEL (1'b0)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_raw   (sw_raw),
        .db_level (db_level),
        .changed  (changed),
        .pressed  (pressed)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s tick %0d: got %b expected %b", tag, tick_no, act, exp);
        end
    endtask

    // Present one raw value for one tick, then check outputs right after
    // the tick's update and once more on the following clock.
    task automatic do_tick(input logic raw_v, input logic exp_lvl, input logic exp_chg);
        int target;
        sw_raw = raw_v;
        target = (tick_no + 1) * T + 1;
        while (edge_cnt < target) begin
            @(posedge clk);
            #1;
        end
        tick_no++;
        check("R2 R3 R4 db_level", db_level, exp_lvl);
        check("R5 changed", changed, exp_chg);
        check("R6 pressed", pressed, ~exp_lvl);
        @(posedge clk);
        #1;
        check("R5 changed drops", changed, 1'b0);
        check("R7 level held", db_level, exp_lvl);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 level in reset", db_level, 1'b1);
        check("R1 pressed in reset", pressed, 1'b0);
        check("R1 changed in reset", changed, 1'b0);
        rst_n = 1'b1;
        tick_no = 0;
        #1;
    endtask

    initial begin
        apply_reset();
        check("R1 level after reset", db_level, 1'b1);
        check("R1 changed after reset", changed, 1'b0);

        for (int i = 0; i < NV; i++) begin
            do_tick(VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R1 R2: reset while a press is half counted, then the first press
        // after reset needs the full press count again.
        do_tick(1'b0, 1'b1, 1'b0);
        sw_raw = 1'b0;
        apply_reset();
        check("R1 level after mid-count reset", db_level, 1'b1);
        do_tick(1'b0, 1'b1, 1'b0);
        do_tick(1'b0, 1'b0, 1'b1);
        // R4: a glitch at the last step of the long release window
        for (int i = 0; i < 5; i++) do_tick(1'b1, 1'b0, 1'b0);
        do_tick(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) do_tick(1'b1, 1'b0, 1'b0);
        do_tick(1'b1, 1'b1, 1'b1);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired: got running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule